// File: doc/BRIEF.md
# Punctured Convolutional Encoder

This block takes a serial stream of data bits, one bit per accepted transfer, and codes each bit with a rate-1/2 convolutional code of constraint length 7. Every input bit yields two coded bits, X and Y. A puncturing stage then removes some of these bits, following a keep pattern chosen by a static rate selector. The bits that survive are packed in order into two-bit symbols for a downstream QPSK mapper. The input stream is normally produced by an MSB-first byte-to-bit converter.

The input uses valid/ready. A bit is taken on every rising clock edge where both `in_valid` and `in_ready` are high. `in_ready` is low while reset is held and goes high one cycle after reset is released. From then on it stays high, because the block can absorb one bit in every cycle. The output has valid only and no back-pressure. A symbol appears on the cycle after the input bit that completes it, and at most one symbol appears per cycle.

The rate selector may change at any time. On the cycle it differs from its previous value, the puncture phase starts again from the start of the new pattern and any half-filled symbol is dropped. The encoder memory is kept across a rate change.

Top module: `pconv_enc`

## Requirements
- R1: While `rst` is high, `out_valid` and `in_ready` are 0 and the six-bit encoder memory is cleared. Example: the first accepted bit after reset, a 1 at rate code 0, produces the symbol 2'b11.
- R2: `in_ready` is high in every cycle after the first clock edge following reset release. A bit is accepted exactly when `in_valid` and `in_ready` are both high at a rising edge.
- R3: Let d0 be the current bit and dk the bit accepted k transfers earlier. The coded bits are X = d0^d1^d2^d3^d6 (generator 171 octal) and Y = d0^d2^d3^d5^d6 (generator 133 octal). Within a bit period, X goes out before Y.
- R4: At rate code 0 (rate 1/2), each accepted bit yields one symbol on the next cycle, with `out_sym[1]` = X and `out_sym[0]` = Y.
- R5: Keep patterns apply per input bit, starting at phase 0 and read from left to right. Code 1 (2/3): X=10, Y=11. Code 2 (3/4): X=101, Y=110. Code 3 (5/6): X=10101, Y=11010. Code 4 (7/8): X=1000101, Y=1111010. The phase advances once per accepted bit and wraps at the pattern length.
- R6: Surviving bits are paired in order of transmission, even across input bit boundaries. The first bit of a pair goes to `out_sym[1]` (I) and the second to `out_sym[0]` (Q).
- R7: In a cycle where `rate_sel` differs from its value in the previous cycle, the phase restarts at 0 under the new pattern and any unpaired bit is dropped. This applies whether or not a bit is accepted in that cycle.
- R8: Cycles with no accepted bit do not advance the encoder or the phase and produce no symbol.
- R9: Rate codes 5, 6 and 7 behave exactly like code 0.
- R10: `out_valid` is high exactly in the cycle after an accepted bit that completes a pair, and for one cycle per symbol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 3 | Code rate selector (0..4, others act as 0) |
| in_valid | input | 1 | Input bit present |
| in_bit | input | 1 | Input data bit |
| in_ready | output | 1 | Block can take a bit |
| out_valid | output | 1 | Symbol present this cycle |
| out_sym | output | 2 | Symbol: bit 1 = I, bit 0 = Q |

## Verification
Every symbol is due exactly one cycle after the accepted bit that supplies its second half. When the driver pushes a predicted symbol, it also records the number of the clock edge on which that bit is accepted. The monitor samples at the falling edge. It requires that `out_valid` be high on exactly that edge's cycle and on no other, so a late, early or extra symbol is reported just as a wrong value is. Rate changes made during idle cycles and with a half-filled pair are included, so that dropping the pending bit and restarting the phase are timed the same way.

// File: rtl/pconv_pkg.sv
package pconv_pkg;
  localparam int RATE_W = 3;
  localparam int PH_W   = 3;
  localparam int PAT_W  = 7;

  typedef enum logic [RATE_W-1:0] {
    RATE_1_2 = 3'd0,
    RATE_2_3 = 3'd1,
    RATE_3_4 = 3'd2,
    RATE_5_6 = 3'd3,
    RATE_7_8 = 3'd4
  } rate_e;

  // last phase index of the keep pattern for a rate code
  function automatic logic [PH_W-1:0] period_last(input logic [RATE_W-1:0] r);
    case (r)
      RATE_2_3: period_last = 3'd1;
      RATE_3_4: period_last = 3'd2;
      RATE_5_6: period_last = 3'd4;
      RATE_7_8: period_last = 3'd6;
      default:  period_last = 3'd0;
    endcase
  endfunction

  // {keep X, keep Y} for a rate code at a phase; patterns left aligned, phase 0 = MSB
  function automatic logic [1:0] keep_bits(input logic [RATE_W-1:0] r,
                                           input logic [PH_W-1:0]   ph);
    logic [PAT_W-1:0] px, py;
    int idx;
    case (r)
      RATE_2_3: begin px = 7'b1000000; py = 7'b1100000; end
      RATE_3_4: begin px = 7'b1010000; py = 7'b1100000; end
      RATE_5_6: begin px = 7'b1010100; py = 7'b1101000; end
      RATE_7_8: begin px = 7'b1000101; py = 7'b1111010; end
      default:  begin px = 7'b1111111; py = 7'b1111111; end
    endcase
    idx = PAT_W - 1 - int'(ph);
    keep_bits = {px[idx], py[idx]};
  endfunction
endpackage

// File: rtl/pconv_shift.sv
module pconv_shift #(
  parameter int          K  = 7,
  parameter logic [K-1:0] GX = 7'o171,
  parameter logic [K-1:0] GY = 7'o133
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic din,
  output logic x_bit,
  output logic y_bit
);
  localparam int MEM_W = K - 1;

  // mem_q[MEM_W-1] holds the most recent past bit
  logic [MEM_W-1:0] mem_q;
  logic [K-1:0]     win;

  assign win   = {din, mem_q};
  assign x_bit = ^(win & GX);
  assign y_bit = ^(win & GY);

  always_ff @(posedge clk) begin
    if (rst)           mem_q <= '0;
    else if (shift_en) mem_q <= win[K-1:1];
  end

  // R1
  mem_clear_chk: assert property (@(posedge clk) rst |=> (mem_q == '0));
  // R3
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (mem_q[MEM_W-1] == $past(din)));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(mem_q));
endmodule

// File: rtl/pconv_phase.sv
module pconv_phase
  import pconv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate,
  input  logic              accept,
  output logic              restart,
  output logic              keep_x,
  output logic              keep_y
);
  logic [RATE_W-1:0] rate_q;
  logic [PH_W-1:0]   ph_q, ph_eff, last;

  assign restart  = (rate != rate_q);
  assign ph_eff   = restart ? '0 : ph_q;
  assign last     = period_last(rate);
  assign {keep_x, keep_y} = keep_bits(rate, ph_eff);

  always_ff @(posedge clk) begin
    rate_q <= rate;
    if (rst)         ph_q <= '0;
    else if (accept) ph_q <= (ph_eff == last) ? '0 : ph_eff + 1'b1;
    else             ph_q <= ph_eff;
  end

  // R5
  ph_range_chk: assert property (@(posedge clk) disable iff (rst)
    ph_q <= period_last(rate_q));
  // R7
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (restart && !accept) |=> (ph_q == '0));
endmodule

// File: rtl/pconv_pack.sv
module pconv_pack (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       flush,
  input  logic       keep_x,
  input  logic       keep_y,
  input  logic       x_bit,
  input  logic       y_bit,
  output logic       sym_valid,
  output logic [1:0] sym
);
  logic       pend_v_q, pend_b_q;
  logic [2:0] lst;
  logic [1:0] n;
  logic       pv;
  logic       vld_n, pend_v_n, pend_b_n;
  logic [1:0] sym_n;

  assign pv = pend_v_q && !flush;

  always_comb begin
    lst = '0;
    n   = '0;
    if (pv) begin
      lst[n] = pend_b_q;
      n      = n + 2'd1;
    end
    if (en && keep_x) begin
      lst[n] = x_bit;
      n      = n + 2'd1;
    end
    if (en && keep_y) begin
      lst[n] = y_bit;
      n      = n + 2'd1;
    end
    if (n >= 2'd2) begin
      vld_n    = 1'b1;
      sym_n    = {lst[0], lst[1]};
      pend_v_n = (n == 2'd3);
      pend_b_n = lst[2];
    end else begin
      vld_n    = 1'b0;
      sym_n    = '0;
      pend_v_n = (n == 2'd1);
      pend_b_n = lst[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v_q  <= 1'b0;
      pend_b_q  <= 1'b0;
      sym_valid <= 1'b0;
      sym       <= '0;
    end else begin
      pend_v_q  <= pend_v_n;
      pend_b_q  <= pend_b_n;
      sym_valid <= vld_n;
      if (vld_n) sym <= sym_n;
    end
  end

  // R10
  out_cause_chk: assert property (@(posedge clk) disable iff (rst)
    sym_valid |-> $past(en));
  // R7
  flush_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (flush && !en) |=> !pend_v_q);
endmodule

// File: rtl/pconv_enc.sv
module pconv_enc
  import pconv_pkg::*;
#(
  parameter int           K  = 7,
  parameter logic [K-1:0] GX = 7'o171,
  parameter logic [K-1:0] GY = 7'o133
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              in_valid,
  input  logic              in_bit,
  output logic              in_ready,
  output logic              out_valid,
  output logic [1:0]        out_sym
);
  logic rdy_q;
  logic accept, restart, keep_x, keep_y, x_bit, y_bit;

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= 1'b1;
  end

  assign in_ready = rdy_q;
  assign accept   = in_valid && rdy_q;

  pconv_shift #(.K(K), .GX(GX), .GY(GY)) u_shift (
    .clk(clk), .rst(rst), .shift_en(accept), .din(in_bit),
    .x_bit(x_bit), .y_bit(y_bit)
  );

  pconv_phase u_phase (
    .clk(clk), .rst(rst), .rate(rate_sel), .accept(accept),
    .restart(restart), .keep_x(keep_x), .keep_y(keep_y)
  );

  pconv_pack u_pack (
    .clk(clk), .rst(rst), .en(accept), .flush(restart),
    .keep_x(keep_x), .keep_y(keep_y), .x_bit(x_bit), .y_bit(y_bit),
    .sym_valid(out_valid), .sym(out_sym)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk) rst |=> (!out_valid && !in_ready));
  // R2
  ready_high_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> in_ready);
  // R4 and R9: every accepted bit at a full-rate code yields a symbol
  half_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && (period_last(rate_sel) == '0)) |=> out_valid);
endmodule

// File: tb/pconv_enc_bench.sv
`timescale 1ns/1ps
module pconv_enc_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] rate_sel = 3'd0;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       in_ready, out_valid;
  logic [1:0] out_sym;

  always #2 clk = ~clk;

  pconv_enc u_pconv_enc (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .in_valid(in_valid),
    .in_bit(in_bit), .in_ready(in_ready), .out_valid(out_valid), .out_sym(out_sym)
  );

  typedef struct {logic [1:0] sym; int tag; string req;} exp_t;
  exp_t q[$];

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference state
  logic [6:0] hist;
  int         ph;
  bit         pv, pb;
  logic [2:0] prev_rate;
  bit         first_bit;
  int         rage;
  int unsigned seed = 32'h1234_5678;

  function automatic int per(input logic [2:0] r);
    case (r)
      3'd1: return 2;
      3'd2: return 3;
      3'd3: return 5;
      3'd4: return 7;
      default: return 1;
    endcase
  endfunction

  function automatic bit kbit(input string s, input int p);
    return s[p] == "1";
  endfunction

  task automatic keeps(input logic [2:0] r, input int p, output bit kx, output bit ky);
    case (r)
      3'd1: begin kx = kbit("10", p);      ky = kbit("11", p); end
      3'd2: begin kx = kbit("101", p);     ky = kbit("110", p); end
      3'd3: begin kx = kbit("10101", p);   ky = kbit("11010", p); end
      3'd4: begin kx = kbit("1000101", p); ky = kbit("1111010", p); end
      default: begin kx = 1; ky = 1; end
    endcase
  endtask

  function automatic bit next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[7];
  endfunction

  task automatic check(input string req, input bit ok, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic drive(input bit v, input bit b, input logic [2:0] r);
    bit x, y, kx, ky, used_pend;
    bit l[3];
    int n;
    string req;
    @(negedge clk);
    in_valid = v; in_bit = b; rate_sel = r;
    if (r != prev_rate) begin
      ph = 0; pv = 0; rage = 0;
    end
    prev_rate = r;
    if (v) begin
      hist = {hist[5:0], b};
      // R3: taps at delays 0,1,2,3,6 and 0,2,3,5,6
      x = hist[0] ^ hist[1] ^ hist[2] ^ hist[3] ^ hist[6];
      y = hist[0] ^ hist[2] ^ hist[3] ^ hist[5] ^ hist[6];
      keeps(r, ph, kx, ky);
      n = 0;
      used_pend = pv;
      if (pv) begin l[n] = pb; n++; end
      if (kx) begin l[n] = x; n++; end
      if (ky) begin l[n] = y; n++; end
      if (first_bit) req = "R1";
      else if (rage < per(r)) req = "R7";
      else if (r >= 3'd5) req = "R9";
      else if (r == 3'd0) req = "R4";
      else if (used_pend) req = "R6";
      else req = "R5";
      if (n >= 2) begin
        q.push_back('{sym: {l[0], l[1]}, tag: cyc + 1, req: req});
        pv = (n == 3); pb = l[2];
      end else begin
        pv = (n == 1); pb = l[0];
      end
      ph = (ph + 1) % per(r);
      rage++;
      first_bit = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0;
    q.delete();
    hist = '0; ph = 0; pv = 0; pb = 0; first_bit = 1; rage = 1000;
    prev_rate = rate_sel;
    repeat (2) @(negedge clk);
    // R1: outputs quiet while reset is held
    check("R1", !out_valid, out_valid, 0);
    check("R1", !in_ready, in_ready, 0);
    rst = 0;
    @(negedge clk);
    // R2: ready one cycle after release
    check("R2", in_ready, in_ready, 1);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          check("R8", 0, out_sym, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(e.req, out_sym == e.sym, out_sym, e.sym);
          check("R10", cyc == e.tag, cyc, e.tag);
        end
      end else if (q.size() > 0 && q[0].tag <= cyc) begin
        exp_t e;
        e = q.pop_front();
        check("R10", 0, 0, e.tag);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 / R3: cleared memory gives 11 for a leading 1
    drive(1, 1, 3'd0);
    for (int i = 0; i < 24; i++) drive((i % 5) != 4, next_rand(), 3'd0);
    for (int r = 1; r <= 4; r++)
      for (int i = 0; i < 30; i++) drive((i % 7) != 6, next_rand(), 3'(r));
    // R7: leave an unpaired bit at 3/4, then change rate
    drive(1, next_rand(), 3'd0);
    for (int i = 0; i < 2; i++) drive(1, next_rand(), 3'd2);
    for (int i = 0; i < 8; i++) drive(1, next_rand(), 3'd1);
    // R7: rate change during an idle cycle with a pending bit
    for (int i = 0; i < 2; i++) drive(1, next_rand(), 3'd4);
    drive(0, 0, 3'd3);
    for (int i = 0; i < 12; i++) drive(1, next_rand(), 3'd3);
    // R9: unused codes
    for (int r = 5; r <= 7; r++)
      for (int i = 0; i < 10; i++) drive(1, next_rand(), 3'(r));
    // R8: long idle stretch then continue
    for (int i = 0; i < 6; i++) drive(0, 1, 3'd7);
    for (int i = 0; i < 10; i++) drive(1, next_rand(), 3'd2);
    // R1: reset in mid stream clears the memory again
    for (int i = 0; i < 5; i++) drive(1, 1, 3'd3);
    rate_sel = 3'd0;
    do_reset();
    drive(1, 1, 3'd0);
    for (int i = 0; i < 6; i++) drive(1, next_rand(), 3'd0);
    for (int i = 0; i < 4; i++) drive(0, 0, 3'd0);
    check("R10", q.size() == 0, q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule